// File: doc/BRIEF.md
# USB Host Command and Status Register Controller

This block holds the software-visible command and status registers of a USB 2.0 host controller and runs the control state machine behind them. The command register carries a run bit, a controller-reset bit, a two-bit frame list size field and enables for the periodic and asynchronous schedules. The status register carries write-one-to-clear event bits and a read-only halted flag.

A schedule engine outside the block talks to it through handshake signals. The block raises `eng_run` while the schedule may execute. It raises `eng_stop_req` when software has cleared the run bit, and it waits for `eng_idle` before it reports halted. A software reset raises `eng_reset_req`. That reset ends when `eng_reset_done` arrives, or after a fixed number of cycles if it does not. The block also gives out a frame-index wrap mask that is decoded from the frame list size.

Software reaches the registers through a plain read/write port. Address 0 is the command register and address 1 is the status register. A read returns data one cycle after it is requested.

Top module: `usbh_cmdsts_ctrl`

## Requirements
- R1: After the synchronous reset, the command register reads 0, the status register reads 0x8000 (halted flag at bit 15, no events), `eng_run`, `eng_stop_req` and `eng_reset_req` are 0, and `fidx_mask` is 0x3FF.
- R2: Command bit 1 drives `sched_periodic_en` and command bit 2 drives `sched_async_en`. A 0 in either bit tells the engine to skip that schedule.
- R3: The frame list size field sits at command bits 5:4 and accepts a write only while `cap_prog_fl` is 1. With `cap_prog_fl` at 0 the field keeps its value. `fidx_mask` is 0x3FF for 00 (1024 entries), 0x1FF for 01 (512 entries) and 0x0FF for 10 (256 entries).
- R4: A write of the reserved size code 11 leaves the field and `fidx_mask` unchanged.
- R5: Writing 1 to the run bit (command bit 0) makes `eng_run` 1 and the halted flag 0 in the next cycle. The halted flag stays 0 while the run bit is 1.
- R6: Clearing the run bit while running makes `eng_stop_req` 1 and `eng_run` 0. The halted flag stays 0 until `eng_idle` is seen, and it is 1 in the cycle after that.
- R7: Writing 1 to a status event bit (bits NEVT-1:0) clears it. Writing 0 to it leaves it unchanged.
- R8: A one-cycle pulse on `evt_in[i]` sets status bit i. If the pulse and a clearing write to that bit land in the same cycle, the bit ends up set.
- R9: Writing 1 to the controller-reset bit (command bit 8) clears the run, enable and size fields and all status events. It raises `eng_reset_req`, and command bit 8 reads 1 until the reset ends, after which it reads 0 and the block is halted.
- R10: While a reset is in progress, register writes (including a 0 to bit 8) and event pulses have no effect.
- R11: The reset ends in the cycle after `eng_reset_done` is seen, or after RST_CYCLES cycles in the reset state, whichever comes first.
- R12: `rdata` shows the addressed register one cycle after `rd_en`. Addresses other than 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after rd_en |
| cap_prog_fl | input | 1 | Capability: frame list size is programmable |
| evt_in | input | NEVT | Status event pulses |
| eng_idle | input | 1 | Engine has no transactions in flight |
| eng_reset_done | input | 1 | Engine finished its reset |
| eng_run | output | 1 | Engine may execute the schedule |
| eng_stop_req | output | 1 | Engine must drain and stop |
| eng_reset_req | output | 1 | Engine must reset |
| sched_periodic_en | output | 1 | Periodic schedule enabled |
| sched_async_en | output | 1 | Asynchronous schedule enabled |
| fidx_mask | output | FIDX_W | Frame-index wrap mask |

## Verification
The hardest cases to reach are the boundary cycles of the reset sequence. One is the timeout, where the reset must last exactly RST_CYCLES cycles. The other is a write of 0 to the reset bit that lands in the middle of the sequence. The bench enters reset from a known halted state and spaces its reads, ignored writes and an ignored event pulse in counted cycles. It then checks the exact cycle in which `eng_reset_req` falls on both the handshake path and the timeout path. The set-wins collision is forced by driving an event pulse and a clearing write on the same clock edge.

// File: rtl/usbh_cmdsts_pkg.sv
package usbh_cmdsts_pkg;
  localparam int CMD_RUN    = 0;
  localparam int CMD_PER    = 1;
  localparam int CMD_ASY    = 2;
  localparam int CMD_FLS    = 4;
  localparam int CMD_RST    = 8;
  localparam int STS_HALT   = 15;
  localparam logic [1:0] FLS_RSVD = 2'b11;

  typedef enum logic [1:0] {
    ST_HALTED = 2'd0,
    ST_RUN    = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_RESET  = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/usbh_cmd_reg.sv
module usbh_cmd_reg
  import usbh_cmdsts_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cap,
  output logic              run_q,
  output logic              run_d,
  output logic              per_q,
  output logic              asy_q,
  output logic [1:0]        fls_q
);
  logic [1:0] fls_w;
  assign fls_w = wdata[CMD_FLS+1:CMD_FLS];

  always_comb begin
    if (clr)     run_d = 1'b0;
    else if (wr) run_d = wdata[CMD_RUN];
    else         run_d = run_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q <= 1'b0;
      per_q <= 1'b0;
      asy_q <= 1'b0;
      fls_q <= 2'b00;
    end else begin
      run_q <= run_d;
      if (wr) begin
        per_q <= wdata[CMD_PER];
        asy_q <= wdata[CMD_ASY];
        if (cap && fls_w != FLS_RSVD) fls_q <= fls_w;
      end
    end
  end
endmodule

// File: rtl/usbh_sts_reg.sv
module usbh_sts_reg #(
  parameter int NEVT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            hold,
  input  logic [NEVT-1:0] evt,
  input  logic            wr,
  input  logic [NEVT-1:0] wmask,
  output logic [NEVT-1:0] ev_q
);
  for (genvar i = 0; i < NEVT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)      ev_q[i] <= 1'b0;
      else if (!hold) begin
        if (evt[i])        ev_q[i] <= 1'b1;
        else if (wr && wmask[i]) ev_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usbh_ctl_fsm.sv
module usbh_ctl_fsm
  import usbh_cmdsts_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_start,
  input  logic run_d,
  input  logic eng_idle,
  input  logic eng_reset_done,
  output logic in_reset,
  output logic halted,
  output logic eng_run,
  output logic eng_stop_req
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

  ctl_state_t st_q, st_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_HALTED: if (rst_start) st_d = ST_RESET;
                 else if (run_d) st_d = ST_RUN;
      ST_RUN:    if (rst_start) st_d = ST_RESET;
                 else if (!run_d) st_d = ST_DRAIN;
      ST_DRAIN:  if (rst_start) st_d = ST_RESET;
                 else if (eng_idle) st_d = run_d ? ST_RUN : ST_HALTED;
      ST_RESET:  if (eng_reset_done || cnt_q == CNT_LAST) st_d = ST_HALTED;
      default:   st_d = ST_HALTED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_HALTED;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (rst_start)            cnt_q <= '0;
      else if (st_q == ST_RESET) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign in_reset     = (st_q == ST_RESET);
  assign halted       = (st_q == ST_HALTED) || (st_q == ST_RESET);
  assign eng_run      = (st_q == ST_RUN);
  assign eng_stop_req = (st_q == ST_DRAIN);
endmodule

// File: rtl/usbh_cmdsts_ctrl.sv
module usbh_cmdsts_ctrl
  import usbh_cmdsts_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int NEVT       = 6,
  parameter int FIDX_W     = 10,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cap_prog_fl,
  input  logic [NEVT-1:0]   evt_in,
  input  logic              eng_idle,
  input  logic              eng_reset_done,
  output logic              eng_run,
  output logic              eng_stop_req,
  output logic              eng_reset_req,
  output logic              sched_periodic_en,
  output logic              sched_async_en,
  output logic [FIDX_W-1:0] fidx_mask
);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(1);

  logic in_reset, halted, rst_start, cmd_wr, sts_wr;
  logic run_q, run_d, per_q, asy_q;
  logic [1:0] fls_q;
  logic [NEVT-1:0] ev_q;
  logic [DATA_W-1:0] cmd_view, sts_view, rd_mux;

  assign cmd_wr    = wr_en && addr == A_CMD && !in_reset;
  assign sts_wr    = wr_en && addr == A_STS && !in_reset;
  assign rst_start = cmd_wr && wdata[CMD_RST];

  usbh_cmd_reg #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .clr(rst_start), .wr(cmd_wr), .wdata(wdata),
    .cap(cap_prog_fl), .run_q(run_q), .run_d(run_d), .per_q(per_q),
    .asy_q(asy_q), .fls_q(fls_q)
  );

  usbh_sts_reg #(.NEVT(NEVT)) u_sts (
    .clk(clk), .rst(rst), .clr(rst_start), .hold(in_reset), .evt(evt_in),
    .wr(sts_wr), .wmask(wdata[NEVT-1:0]), .ev_q(ev_q)
  );

  usbh_ctl_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .rst_start(rst_start), .run_d(run_d),
    .eng_idle(eng_idle), .eng_reset_done(eng_reset_done),
    .in_reset(in_reset), .halted(halted), .eng_run(eng_run),
    .eng_stop_req(eng_stop_req)
  );

  always_comb begin
    cmd_view = '0;
    cmd_view[CMD_RUN] = run_q;
    cmd_view[CMD_PER] = per_q;
    cmd_view[CMD_ASY] = asy_q;
    cmd_view[CMD_FLS+1:CMD_FLS] = fls_q;
    cmd_view[CMD_RST] = in_reset;
    sts_view = '0;
    sts_view[NEVT-1:0] = ev_q;
    sts_view[STS_HALT] = halted;
    case (addr)
      A_CMD:   rd_mux = cmd_view;
      A_STS:   rd_mux = sts_view;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign eng_reset_req     = in_reset;
  assign sched_periodic_en = per_q;
  assign sched_async_en    = asy_q;
  assign fidx_mask         = {FIDX_W{1'b1}} >> fls_q;
endmodule

// File: rtl/usbh_cmdsts_chk.sv
module usbh_cmdsts_chk #(
  parameter int NEVT   = 6,
  parameter int FIDX_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cap_prog_fl,
  input logic [NEVT-1:0]   evt_in,
  input logic              eng_idle,
  input logic              eng_reset_done,
  input logic              eng_run,
  input logic              eng_stop_req,
  input logic              eng_reset_req,
  input logic              sched_periodic_en,
  input logic              sched_async_en,
  input logic [FIDX_W-1:0] fidx_mask,
  input logic              run_q,
  input logic              halted,
  input logic              rst_start,
  input logic [NEVT-1:0]   ev_q
);
  localparam logic [FIDX_W-1:0] M0 = {FIDX_W{1'b1}};

  a_r5_run_not_halted: assert property (@(posedge clk) disable iff (rst)
    run_q |-> !halted);

  a_r6_no_halt_before_idle: assert property (@(posedge clk) disable iff (rst)
    (eng_stop_req && !eng_idle) |=> (!halted || eng_reset_req));

  a_r9_reset_clears_engine: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_reset_req) |-> (!eng_run && !sched_periodic_en && !sched_async_en));

  a_r11_done_ends_reset: assert property (@(posedge clk) disable iff (rst)
    (eng_reset_req && eng_reset_done) |=> !eng_reset_req);

  a_r3_fls_locked: assert property (@(posedge clk) disable iff (rst)
    (!cap_prog_fl && !rst_start) |=> $stable(fidx_mask));

  a_r4_mask_legal: assert property (@(posedge clk) disable iff (rst)
    (fidx_mask == M0) || (fidx_mask == (M0 >> 1)) || (fidx_mask == (M0 >> 2)));

  for (genvar i = 0; i < NEVT; i++) begin : g_ev
    a_r8_event_sets: assert property (@(posedge clk) disable iff (rst)
      (evt_in[i] && !eng_reset_req && !rst_start) |=> ev_q[i]);
  end
endmodule

bind usbh_cmdsts_ctrl usbh_cmdsts_chk #(.NEVT(NEVT), .FIDX_W(FIDX_W)) u_chk (
  .clk(clk), .rst(rst), .cap_prog_fl(cap_prog_fl), .evt_in(evt_in),
  .eng_idle(eng_idle), .eng_reset_done(eng_reset_done), .eng_run(eng_run),
  .eng_stop_req(eng_stop_req), .eng_reset_req(eng_reset_req),
  .sched_periodic_en(sched_periodic_en), .sched_async_en(sched_async_en),
  .fidx_mask(fidx_mask), .run_q(run_q), .halted(halted),
  .rst_start(rst_start), .ev_q(ev_q)
);

// File: tb/usbh_cmdsts_ctrl_tb.sv
module usbh_cmdsts_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;
  localparam int NEVT = 6;
  localparam int FIDX_W = 10;
  localparam int RST_CYCLES = 16;
  localparam logic [31:0] HALT = 32'h8000;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, cap_prog_fl = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic [NEVT-1:0] evt_in = '0;
  logic eng_idle = 1, eng_reset_done = 0;
  logic eng_run, eng_stop_req, eng_reset_req, sched_periodic_en, sched_async_en;
  logic [FIDX_W-1:0] fidx_mask;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbh_cmdsts_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NEVT(NEVT),
    .FIDX_W(FIDX_W), .RST_CYCLES(RST_CYCLES)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_prog_fl(cap_prog_fl), .evt_in(evt_in),
    .eng_idle(eng_idle), .eng_reset_done(eng_reset_done), .eng_run(eng_run),
    .eng_stop_req(eng_stop_req), .eng_reset_req(eng_reset_req),
    .sched_periodic_en(sched_periodic_en), .sched_async_en(sched_async_en),
    .fidx_mask(fidx_mask));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pulse_evt(input int i);
    @(negedge clk); evt_in[i] = 1;
    @(negedge clk); evt_in = '0;
  endtask

  task automatic t_reset_state;
    rd(0, v); chk("R1 cmd", v, 0);
    rd(1, v); chk("R1 sts", v, HALT);
    chk("R1 run", eng_run, 0); chk("R1 stop", eng_stop_req, 0);
    chk("R1 rreq", eng_reset_req, 0); chk("R1 mask", fidx_mask, 32'h3FF);
  endtask

  task automatic t_enables;
    wr(0, 32'h2);
    chk("R2 per on", sched_periodic_en, 1); chk("R2 asy off", sched_async_en, 0);
    wr(0, 32'h4);
    chk("R2 per off", sched_periodic_en, 0); chk("R2 asy on", sched_async_en, 1);
    wr(0, 32'h0);
  endtask

  task automatic t_fls;
    cap_prog_fl = 0; wr(0, 32'h10);
    rd(0, v); chk("R3 locked field", v, 0); chk("R3 locked mask", fidx_mask, 32'h3FF);
    cap_prog_fl = 1; wr(0, 32'h10);
    chk("R3 512 mask", fidx_mask, 32'h1FF);
    wr(0, 32'h20);
    chk("R3 256 mask", fidx_mask, 32'h0FF);
    wr(0, 32'h30);
    rd(0, v); chk("R4 reserved field", v, 32'h20); chk("R4 reserved mask", fidx_mask, 32'h0FF);
    wr(0, 32'h00); chk("R3 1024 mask", fidx_mask, 32'h3FF);
    cap_prog_fl = 0;
  endtask

  task automatic t_run_stop;
    eng_idle = 1; wr(0, 32'h1);
    chk("R5 run", eng_run, 1);
    rd(1, v); chk("R5 not halted", v, 0);
    @(negedge clk); eng_idle = 0;
    wr(0, 32'h0);
    chk("R6 stop req", eng_stop_req, 1); chk("R6 run off", eng_run, 0);
    repeat (3) @(negedge clk);
    rd(1, v); chk("R6 still draining", v, 0);
    eng_idle = 1;
    @(negedge clk);
    chk("R6 stop done", eng_stop_req, 0);
    rd(1, v); chk("R6 halted after idle", v, HALT);
  endtask

  task automatic t_status;
    pulse_evt(2);
    rd(1, v); chk("R8 event set", v, HALT | 32'h4);
    wr(1, 32'h1);
    rd(1, v); chk("R7 write0 keeps", v, HALT | 32'h4);
    wr(1, 32'h4);
    rd(1, v); chk("R7 w1c clears", v, HALT);
    @(negedge clk); evt_in[3] = 1; wr_en = 1; addr = 1; wdata = 32'h8;
    @(negedge clk); evt_in = '0; wr_en = 0;
    rd(1, v); chk("R8 set wins", v, HALT | 32'h8);
    wr(1, 32'h8);
  endtask

  task automatic t_soft_reset;
    wr(0, 32'h6); pulse_evt(1);
    wr(0, 32'h101);
    chk("R9 reset req", eng_reset_req, 1);
    chk("R9 per cleared", sched_periodic_en, 0);
    rd(0, v); chk("R9 bit reads 1", v, 32'h100);
    rd(1, v); chk("R9 events cleared", v, HALT);
    wr(0, 32'h0);
    rd(0, v); chk("R10 write0 ignored", v, 32'h100);
    pulse_evt(0);
    @(negedge clk); eng_reset_done = 1;
    @(negedge clk); eng_reset_done = 0;
    chk("R11 done ends reset", eng_reset_req, 0);
    rd(0, v); chk("R9 bit self clears", v, 0);
    rd(1, v); chk("R10 event ignored", v, HALT);
  endtask

  task automatic t_reset_timeout;
    wr(0, 32'h100);
    repeat (RST_CYCLES - 1) @(negedge clk);
    chk("R11 still resetting", eng_reset_req, 1);
    @(negedge clk);
    chk("R11 timeout ends", eng_reset_req, 0);
  endtask

  task automatic t_read_port;
    rd(2, v); chk("R12 unmapped", v, 0);
    wr(0, 32'h4);
    @(negedge clk); rd_en = 1; addr = 0;
    @(negedge clk); rd_en = 0; chk("R12 latency", rdata, 32'h4);
    wr(0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_state();
    t_enables();
    t_fls();
    t_run_stop();
    t_status();
    t_soft_reset();
    t_reset_timeout();
    t_read_port();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule